// File: doc/BRIEF.md
# Paged Instruction Fetch Aligner

This front-end unit sits between instruction fetch and decode. It takes a stream of 16-bit instruction words, each fetched from an even byte address, and turns them into whole instructions. The high byte of every word comes first in program order. Every instruction is an even number of bytes long, so each one starts in the high byte of a word.

If the first byte of an instruction has one of three prefix values, it selects an alternate opcode page and the real opcode follows it. Any other first byte is itself an opcode on page 0. The unit shows the page and opcode of the word at its input on a lookup port. An external table answers with the total byte count in the same cycle. The unit then collects the remaining words and presents one record. The record holds the page, the opcode, the byte count, an error flag and the operand bytes, left-justified and zero-filled.

Words enter through a valid/ready handshake, and the record leaves through another. A flush input drops whatever is being assembled or held, for example after a branch redirect.

Top module: `fetch_aligner`

## Requirements
- R1: A first byte of 0x17, 0x27 or 0x37 is a prefix that selects page 1, 2 or 3 (its bits 5:4). The byte after it is the opcode, and the operand bytes start at the third instruction byte.
- R2: Any other first byte gives page 0, and that byte is the opcode. The first operand byte is the low byte of the same word.
- R3: lenPage and lenOpcode always show the page and opcode that the word now on wordData would give if it were the first word of an instruction. The byte count read back on lenBytes is used only when that word is accepted as a first word.
- R4: A legal count of 2 completes from one accepted word. insnValid rises in the cycle after that word is accepted.
- R5: A legal count of 4 or 6 takes 2 or 3 accepted words. The record reports the count, and its operand bytes appear in program order from the most significant byte down, with every byte past the instruction's end set to zero.
- R6: A count that is odd, zero or above 6 produces a record after the single first word. That record has insnErr=1, a count of 2, and the operands taken from those two bytes. The next word starts a new instruction.
- R7: While insnValid is high and insnReady is low, wordReady stays low and every record field holds its value.
- R8: While flush is high, wordReady is low. One cycle after flush, insnValid is low, and any partial instruction is discarded, so the next accepted word is treated as a first word.
- R9: After reset, insnValid is 0 and wordReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard partial and held instructions |
| wordValid | input | 1 | Fetched word present |
| wordReady | output | 1 | Unit accepts the word this cycle |
| wordData | input | 16 | Fetched word, high byte earlier |
| lenPage | output | 2 | Lookup page for the word on wordData |
| lenOpcode | output | 8 | Lookup opcode for the word on wordData |
| lenBytes | input | LEN_W (4) | Total instruction byte count from the table |
| insnValid | output | 1 | Record available |
| insnReady | input | 1 | Consumer takes the record |
| insnPage | output | 2 | Opcode page of the record |
| insnOpcode | output | 8 | Opcode of the record |
| insnCount | output | 3 | Total byte count, prefix included |
| insnErr | output | 1 | The table returned an illegal count |
| insnOperands | output | 40 | Operand bytes, earliest in bits 39:32 |

## Verification
The hardest case to reach is a flush that lands in the middle of a multi-word instruction. If the flush does not fully drop the partial state, the next word is silently taken as the tail of the old instruction. A directed sequence sends the first word of a 6-byte instruction, applies flush with a word still presented, and then sends a 2-byte instruction whose record must appear on its own. Random traffic with gaps on both handshakes mixes all four pages and every legal and illegal count, and each record is compared against a model built from the bytes that were sent.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int unsigned MaxLen    = 6;
  localparam int unsigned MaxWords  = MaxLen / 2;
  localparam int unsigned IdxW      = $clog2(MaxWords);
  localparam int unsigned CntW      = $clog2(MaxLen + 1);
  localparam int unsigned OpndBytes = MaxLen - 1;

  typedef struct packed {
    logic            clear;
    logic            loadFirst;
    logic            loadNext;
    logic [IdxW-1:0] wordIdx;
    logic [CntW-1:0] count;
    logic            err;
  } strobe_t;

  // prefix bytes: 0x17, 0x27, 0x37
  function automatic logic isPrefix(input logic [7:0] b);
    return (b[3:0] == 4'h7) && (b[7:6] == 2'b00) && (b[5:4] != 2'b00);
  endfunction
endpackage

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import fa_pkg::*;
#(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wordValid,
  output logic             wordReady,
  input  logic [LEN_W-1:0] lenBytes,
  input  logic             insnReady,
  output logic             insnValid,
  output strobe_t          strobe
);
  typedef enum logic [1:0] {S_FIRST, S_GATHER, S_HOLD} state_t;

  state_t          state;
  logic [IdxW-1:0] wordIdx;
  logic [IdxW-1:0] lastIdx;
  logic            accept;
  logic            lenBad;

  assign wordReady = (state != S_HOLD) && !flush;
  assign accept    = wordValid && wordReady;
  assign insnValid = (state == S_HOLD);
  assign lenBad    = lenBytes[0] || (lenBytes == '0) || (lenBytes > LEN_W'(MaxLen));

  always_comb begin
    strobe           = '0;
    strobe.clear     = flush;
    strobe.loadFirst = accept && (state == S_FIRST);
    strobe.loadNext  = accept && (state == S_GATHER);
    strobe.wordIdx   = wordIdx;
    strobe.err       = lenBad;
    strobe.count     = lenBad ? CntW'(2) : CntW'(lenBytes);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_FIRST;
      wordIdx <= '0;
      lastIdx <= '0;
    end else if (flush) begin
      state   <= S_FIRST;
      wordIdx <= '0;
    end else begin
      unique case (state)
        S_FIRST: if (accept) begin
          if (lenBad || (lenBytes == LEN_W'(2))) begin
            state <= S_HOLD;
          end else begin
            state   <= S_GATHER;
            wordIdx <= IdxW'(1);
            lastIdx <= IdxW'((lenBytes >> 1) - LEN_W'(1));
          end
        end
        S_GATHER: if (accept) begin
          if (wordIdx == lastIdx) state <= S_HOLD;
          else                    wordIdx <= wordIdx + IdxW'(1);
        end
        S_HOLD: if (insnReady) state <= S_FIRST;
        default: state <= S_FIRST;
      endcase
    end
  end

  p_short_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIRST && accept && !lenBad && lenBytes == LEN_W'(2)) |=> insnValid);

  p_bad_len_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIRST && accept && lenBad) |=> insnValid);

  p_flush_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !insnValid);

  p_gather_needs_words_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIRST && accept && !lenBad && lenBytes > LEN_W'(2)) |=> !insnValid);
endmodule

// File: rtl/fa_datapath.sv
module fa_datapath
  import fa_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobe_t                strobe,
  input  logic [15:0]            wordData,
  output logic [1:0]             lookPage,
  output logic [7:0]             lookOpcode,
  output logic [1:0]             insnPage,
  output logic [7:0]             insnOpcode,
  output logic [CntW-1:0]        insnCount,
  output logic                   insnErr,
  output logic [8*OpndBytes-1:0] insnOperands
);
  logic            firstPre;
  logic [7:0]      byteBuf [MaxLen];
  logic [1:0]      pageR;
  logic [7:0]      opcR;
  logic [CntW-1:0] cntR;
  logic            errR;

  assign firstPre   = isPrefix(wordData[15:8]);
  assign lookPage   = firstPre ? wordData[13:12] : 2'd0;
  assign lookOpcode = firstPre ? wordData[7:0]   : wordData[15:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MaxLen; i++) byteBuf[i] <= '0;
      pageR <= '0;
      opcR  <= '0;
      cntR  <= '0;
      errR  <= 1'b0;
    end else if (strobe.loadFirst) begin
      for (int i = 2; i < MaxLen; i++) byteBuf[i] <= '0;
      byteBuf[0] <= wordData[15:8];
      byteBuf[1] <= wordData[7:0];
      pageR      <= lookPage;
      opcR       <= lookOpcode;
      cntR       <= strobe.count;
      errR       <= strobe.err;
    end else if (strobe.loadNext) begin
      for (int w = 1; w < MaxWords; w++) begin
        if (strobe.wordIdx == IdxW'(w)) begin
          byteBuf[2*w]   <= wordData[15:8];
          byteBuf[2*w+1] <= wordData[7:0];
        end
      end
    end
  end

  for (genvar j = 0; j < OpndBytes; j++) begin : g_opnd
    logic [7:0] preByte;
    if (j + 2 < MaxLen) begin : g_in
      assign preByte = byteBuf[j+2];
    end else begin : g_out
      assign preByte = 8'h00;
    end
    assign insnOperands[8*(OpndBytes-j)-1 -: 8] = (pageR != 2'd0) ? preByte : byteBuf[j+1];
  end

  assign insnPage   = pageR;
  assign insnOpcode = opcR;
  assign insnCount  = cntR;
  assign insnErr    = errR;
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int unsigned LEN_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   wordValid,
  output logic                   wordReady,
  input  logic [15:0]            wordData,
  output logic [1:0]             lenPage,
  output logic [7:0]             lenOpcode,
  input  logic [LEN_W-1:0]       lenBytes,
  output logic                   insnValid,
  input  logic                   insnReady,
  output logic [1:0]             insnPage,
  output logic [7:0]             insnOpcode,
  output logic [CntW-1:0]        insnCount,
  output logic                   insnErr,
  output logic [8*OpndBytes-1:0] insnOperands
);
  strobe_t strobe;

  fa_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wordValid (wordValid),
    .wordReady (wordReady),
    .lenBytes  (lenBytes),
    .insnReady (insnReady),
    .insnValid (insnValid),
    .strobe    (strobe)
  );

  fa_datapath u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .wordData     (wordData),
    .lookPage     (lenPage),
    .lookOpcode   (lenOpcode),
    .insnPage     (insnPage),
    .insnOpcode   (insnOpcode),
    .insnCount    (insnCount),
    .insnErr      (insnErr),
    .insnOperands (insnOperands)
  );

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (insnValid && !insnReady) |=> (insnValid && $stable(insnPage) && $stable(insnOpcode)
      && $stable(insnCount) && $stable(insnErr) && $stable(insnOperands)));

  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (insnValid && !insnReady && !flush) |=> !wordReady);

  p_count_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (insnValid && !insnErr) |-> (insnCount[0] == 1'b0 && insnCount != '0
      && insnCount <= CntW'(MaxLen)));

  p_err_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (insnValid && insnErr) |-> (insnCount == CntW'(2)));
endmodule

// File: tb/tb_fetch_aligner.sv
module tb_fetch_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic [15:0] wordData = '0;
  logic [1:0]  lenPage;
  logic [7:0]  lenOpcode;
  logic [3:0]  lenBytes;
  logic        insnValid;
  logic        insnReady = 1'b0;
  logic [1:0]  insnPage;
  logic [7:0]  insnOpcode;
  logic [2:0]  insnCount;
  logic        insnErr;
  logic [39:0] insnOperands;

  typedef struct packed {
    logic [1:0]  page;
    logic [7:0]  opc;
    logic [2:0]  cnt;
    logic        err;
    logic [39:0] opnd;
  } rec_t;

  int   nChecks = 0;
  int   nFails  = 0;
  bit   monOn   = 0;
  bit   gapsOn  = 0;
  bit   ended   = 0;
  rec_t expQ[$];

  always #5 clk = ~clk;

  fetch_aligner #(.LEN_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wordValid(wordValid), .wordReady(wordReady),
    .wordData(wordData), .lenPage(lenPage), .lenOpcode(lenOpcode), .lenBytes(lenBytes),
    .insnValid(insnValid), .insnReady(insnReady), .insnPage(insnPage), .insnOpcode(insnOpcode),
    .insnCount(insnCount), .insnErr(insnErr), .insnOperands(insnOperands)
  );

  // external length table, with illegal entries (3 and 8)
  function automatic logic [3:0] benchLen(input logic [1:0] pg, input logic [7:0] op);
    logic [2:0] k;
    k = op[2:0] + {1'b0, pg};
    case (k)
      3'd0, 3'd3: return 4'd2;
      3'd1, 3'd4: return 4'd4;
      3'd2, 3'd5: return 4'd6;
      3'd6:       return 4'd3;
      default:    return 4'd8;
    endcase
  endfunction

  always_comb lenBytes = benchLen(lenPage, lenOpcode);

  function automatic void buildInsn(input logic [1:0] pg, input logic [7:0] op,
                                    output rec_t e, output logic [15:0] w [3], output int nw);
    logic [7:0] b [6];
    logic [3:0] len;
    bit bad;
    int st, used;
    len = benchLen(pg, op);
    bad = len[0] || (len == 0) || (len > 6);
    for (int i = 0; i < 6; i++) b[i] = 8'($urandom);
    if (pg != 0) begin b[0] = {2'b00, pg, 4'h7}; b[1] = op; st = 2; end
    else begin b[0] = op; st = 1; end
    used = bad ? 2 : int'(len);
    nw = used / 2;
    for (int i = 0; i < 3; i++) w[i] = {b[2*i], b[2*i+1]};
    e.page = pg; e.opc = op; e.cnt = 3'(used); e.err = bad; e.opnd = '0;
    for (int j = 0; j < 5; j++) if (st + j < used) e.opnd[39-8*j -: 8] = b[st+j];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic rec_t curRec();
    rec_t r;
    r.page = insnPage; r.opc = insnOpcode; r.cnt = insnCount; r.err = insnErr; r.opnd = insnOperands;
    return r;
  endfunction

  function automatic string reqOf(input rec_t e);
    if (e.err) return "R6";
    if (e.page != 0) return "R1/R5";
    return "R2/R5";
  endfunction

  task automatic pushWord(input logic [15:0] w);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      if (gapsOn && ($urandom % 4 == 0)) wordValid = 1'b0;
      else begin
        wordValid = 1'b1; wordData = w;
        #1;
        if (wordReady) done = 1;
      end
    end
  endtask

  task automatic dropWord();
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic waitRecord(input rec_t e, input string req);
    int t = 0;
    do begin @(negedge clk); #2; t++; end while (!insnValid && t < 50);
    check(insnValid == 1'b1, req, "record appears", 64'(insnValid), 64'd1);
    check(curRec() == e, req, "record fields", 64'(curRec()), 64'(e));
    insnReady = 1'b1;
    @(negedge clk);
    insnReady = 1'b0;
  endtask

  // random consumer
  always @(negedge clk) if (monOn) insnReady = ($urandom % 4 != 0);

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (monOn && insnValid && insnReady) begin
      if (expQ.size() == 0) check(1'b0, "R5", "unexpected record", 64'(curRec()), 64'd0);
      else begin
        rec_t e;
        e = expQ.pop_front();
        check(curRec() == e, reqOf(e), "random record", 64'(curRec()), 64'(e));
      end
    end
  end

  initial begin
    rec_t e;
    logic [15:0] w [3];
    int nw;
    logic [39:0] held;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(insnValid == 1'b0, "R9", "insnValid after reset", 64'(insnValid), 64'd0);
    check(wordReady == 1'b1, "R9", "wordReady after reset", 64'(wordReady), 64'd1);

    // R3 lookup without accepting
    wordData = 16'h275A; #1;
    check({lenPage, lenOpcode} == {2'd2, 8'h5A}, "R3", "prefix lookup", 64'({lenPage, lenOpcode}), 64'({2'd2, 8'h5A}));
    wordData = 16'h8833; #1;
    check({lenPage, lenOpcode} == {2'd0, 8'h88}, "R3", "page0 lookup", 64'({lenPage, lenOpcode}), 64'({2'd0, 8'h88}));

    // R4: two-byte page-0 instruction, valid the cycle after acceptance
    buildInsn(2'd0, 8'h80, e, w, nw);
    pushWord(w[0]);
    dropWord(); #1;
    check(insnValid == 1'b1, "R4", "valid one cycle after word", 64'(insnValid), 64'd1);
    check(wordReady == 1'b0, "R7", "wordReady low while held", 64'(wordReady), 64'd0);
    waitRecord(e, "R4");

    // R1 + R5: page 3, six bytes, last operand slot zero
    buildInsn(2'd3, 8'h47, e, w, nw);
    for (int i = 0; i < nw; i++) pushWord(w[i]);
    dropWord();
    waitRecord(e, "R1");

    // R6: illegal length then a new instruction
    buildInsn(2'd0, 8'h86, e, w, nw);
    pushWord(w[0]); dropWord();
    waitRecord(e, "R6");
    buildInsn(2'd0, 8'h87, e, w, nw);
    pushWord(w[0]); dropWord();
    waitRecord(e, "R6");
    buildInsn(2'd0, 8'h80, e, w, nw);
    pushWord(w[0]); dropWord();
    waitRecord(e, "R6");

    // R8: flush in the middle of a six-byte instruction
    buildInsn(2'd0, 8'h82, e, w, nw);
    pushWord(w[0]);
    @(negedge clk);
    flush = 1'b1; wordValid = 1'b1; wordData = 16'h1234; #1;
    check(wordReady == 1'b0, "R8", "wordReady during flush", 64'(wordReady), 64'd0);
    @(negedge clk);
    flush = 1'b0; wordValid = 1'b0;
    buildInsn(2'd0, 8'h80, e, w, nw);
    pushWord(w[0]); dropWord();
    waitRecord(e, "R8");

    // R7 stall, then R8 flush of a held record
    buildInsn(2'd0, 8'h80, e, w, nw);
    pushWord(w[0]); dropWord(); #1;
    held = insnOperands;
    repeat (3) @(negedge clk);
    #1;
    check(insnValid == 1'b1, "R7", "held under stall", 64'(insnValid), 64'd1);
    check(curRec() == e, "R7", "fields stable under stall", 64'(curRec()), 64'(e));
    check(wordReady == 1'b0, "R7", "no accept under stall", 64'(wordReady), 64'd0);
    check(insnOperands == held, "R7", "operands stable", 64'(insnOperands), 64'(held));
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0; #1;
    check(insnValid == 1'b0, "R8", "held record dropped", 64'(insnValid), 64'd0);

    // random phase
    monOn = 1; gapsOn = 1;
    for (int n = 0; n < 400; n++) begin
      logic [1:0] pg;
      logic [7:0] op;
      pg = 2'($urandom);
      op = 8'($urandom);
      if (pg == 0 && op[3:0] == 4'h7 && op[7:6] == 2'b00 && op[5:4] != 2'b00) op = op ^ 8'h40;
      buildInsn(pg, op, e, w, nw);
      expQ.push_back(e);
      for (int i = 0; i < nw; i++) pushWord(w[i]);
    end
    dropWord();
    for (int t = 0; t < 2000 && expQ.size() != 0; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R5", "all records delivered", 64'(expQ.size()), 64'd0);
    monOn = 0; gapsOn = 0; insnReady = 1'b0;

    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule